// File: doc/BRIEF.md
# ACPI sleep-state gate-drive controller

This block turns the platform's sleep-control signals (the active-low S3 and S5 sleep requests and the main-supply power-good flag) into one of three power states, S0 (working), S3 (suspend to RAM) and S5 (soft off). It then drives eight external MOSFET gate enables. Each enable decides whether a supply rail is fed from the main rails, fed from standby, or left off. The state machine accepts only legal moves. It comes out of reset in S5, never jumps from S3 to S5, and stays in S0 when power-good drops while both sleep requests stay high.

Two strap-style inputs pick which dual rails stay alive from standby, but only while in S5. A type-detect input selects the graphics rail voltage. A block-level enable, a supply-good flag and a latched over-current fault can each shut every gate off and force S5. On every state change, gates that turn off drop one clock before gates that turn on rise. This break-before-make order keeps a main-rail FET and its standby partner from ever being on together.

Top module: `slp_gate_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `state_o` reads S5 (2'b10) and every bit of `gate_o` is 0.
- R2: State codes on `state_o` are S0 = 2'b00, S3 = 2'b01 and S5 = 2'b10. S5 moves to S0 only when `slp3_n`=1, `slp5_n`=1 and `pwr_ok`=1 are all accepted.
- R3: From S0, the accepted pattern `slp3_n`=0, `slp5_n`=1 selects S3, and `slp3_n`=0, `slp5_n`=0 selects S5.
- R4: S3 never moves straight to S5; S3 can only leave to S0, on the same pattern as R2. S5 never moves to S3.
- R5: In S0, `pwr_ok` going low while `slp3_n` and `slp5_n` stay high leaves the state at S0.
- R6: The gate bits are: bit0 standby feed of the 5 V dual rail, bit1 and bit2 main feed of the 5 V and 3.3 V dual rails, bit3 standby feed of the 3.3 V dual rail, bit4 main feed of the memory rail, bit5 standby feed of the memory rail, bit6 graphics regulator, bit7 1.8 V regulator. In steady state with the block enabled, S0 gives 8'hD6 and S3 gives 8'hE9.
- R7: In S5, bit0 follows `usb_sb_en` and bit3 follows `pci_sb_en`, so the steady value is 8'hC0 plus those two bits. In S0 and S3 these two inputs change no gate.
- R8: Bits 6 and 7 are high in every state while `en`=1, `supply_good`=1 and no fault is latched.
- R9: `agp_sel_o` equals `agp_type_hi` delayed by one clock (1 = 3.3 V, 0 = 1.5 V).
- R10: The sleep inputs pass through a synchroniser. A combination must stay stable for two synchronised cycles before the state machine sees it, so a one-cycle pulse changes nothing.
- R11: `en`=0, `supply_good`=0 or a latched fault forces S5 and all gates to 0 on the next clock. A one-cycle `oc_fault` pulse stays latched until `en` goes low or supply-good is lost.
- R12: Gates that turn off fall one clock before gates that turn on rise, so no bit rises in a cycle where another bit falls. The pairs bit0/bit1, bit2/bit3 and bit4/bit5 are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slp3_n | input | 1 | Active-low suspend request (asynchronous) |
| slp5_n | input | 1 | Active-low soft-off request (asynchronous) |
| pwr_ok | input | 1 | Main supply good (asynchronous) |
| usb_sb_en | input | 1 | Keep 5 V dual rail on standby in S5 |
| pci_sb_en | input | 1 | Keep 3.3 V dual rail on standby in S5 |
| agp_type_hi | input | 1 | Graphics rail type detect, 1 = 3.3 V |
| en | input | 1 | Block enable; a low level clears the fault latch |
| supply_good | input | 1 | Standby supply above lockout |
| oc_fault | input | 1 | Over-current detected on a protected rail |
| gate_o | output | 8 | Gate enables, bit map in R6 |
| state_o | output | 2 | Current power state, codes in R2 |
| agp_sel_o | output | 1 | Graphics rail voltage select |

## Verification
The checker enforces on every cycle the pair exclusion and the break-before-make ordering of the gates. It also catches any S3-to-S5 or S5-to-S3 move while enabled, the one-clock shutdown when the run condition is lost, the reset state and the graphics select delay. Only the bench scenarios can show the steady gate values for each state and strap setting. The same holds for the rejection of a one-cycle glitch, the latched fault surviving the end of its pulse, and recovery through the enable pin.

// File: rtl/slp_pkg.sv
package slp_pkg;

   localparam int NUM_GATES = 8;

   // gate bit positions
   localparam int GB_SB5   = 0;
   localparam int GB_MN5   = 1;
   localparam int GB_MN33  = 2;
   localparam int GB_SB33  = 3;
   localparam int GB_MNMEM = 4;
   localparam int GB_SBMEM = 5;
   localparam int GB_GFX   = 6;
   localparam int GB_CORE  = 7;

   typedef enum logic [1:0] {
      PST_S0 = 2'b00,
      PST_S3 = 2'b01,
      PST_S5 = 2'b10
   } pstate_e;

   function automatic logic [NUM_GATES-1:0] gate_target(
      input pstate_e st,
      input logic    usb_keep,
      input logic    pci_keep,
      input logic    run
   );
      logic [NUM_GATES-1:0] t;
      t = '0;
      if (run) begin
         t[GB_GFX]  = 1'b1;
         t[GB_CORE] = 1'b1;
         case (st)
            PST_S0: begin
               t[GB_MN5]   = 1'b1;
               t[GB_MN33]  = 1'b1;
               t[GB_MNMEM] = 1'b1;
            end
            PST_S3: begin
               t[GB_SB5]   = 1'b1;
               t[GB_SB33]  = 1'b1;
               t[GB_SBMEM] = 1'b1;
            end
            default: begin
               t[GB_SB5]  = usb_keep;
               t[GB_SB33] = pci_keep;
            end
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/slp_in_filter.sv
module slp_in_filter #(
   parameter int WIDTH         = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int CW = $clog2(STABLE_CYCLES + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("slp_in_filter: SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYCLES < 1) begin : g_bad_stable
      $error("slp_in_filter: STABLE_CYCLES must be at least 1");
   end

   logic [WIDTH-1:0] stg [SYNC_STAGES];

   for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
         end
      end
   end

   logic [WIDTH-1:0] cand_q;
   logic [CW-1:0]    cnt_q;
   logic [WIDTH-1:0] filt_q;
   wire  [WIDTH-1:0] synced = stg[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         cand_q <= '0;
         cnt_q  <= '0;
         filt_q <= '0;
      end else if (synced != cand_q) begin
         cand_q <= synced;
         cnt_q  <= '0;
      end else if (cnt_q != CW'(STABLE_CYCLES - 1)) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         filt_q <= cand_q;
      end
   end

   assign dout = filt_q;

endmodule

// File: rtl/slp_state_fsm.sv
module slp_state_fsm
   import slp_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    run_ok,
   input  logic    s3n,
   input  logic    s5n,
   input  logic    pok,
   output pstate_e st
);
   pstate_e st_q;
   wire want_s0 = s3n & s5n & pok;

   always_ff @(posedge clk) begin
      if (rst || !run_ok) begin
         st_q <= PST_S5;
      end else begin
         case (st_q)
            PST_S0: begin
               if (!s3n && s5n)       st_q <= PST_S3;
               else if (!s3n && !s5n) st_q <= PST_S5;
            end
            PST_S3: if (want_s0) st_q <= PST_S0;
            PST_S5: if (want_s0) st_q <= PST_S0;
            default:             st_q <= PST_S5;
         endcase
      end
   end

   assign st = st_q;

endmodule

// File: rtl/slp_gate_seq.sv
module slp_gate_seq
   import slp_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  pstate_e              st,
   input  logic                 run_ok,
   input  logic                 usb_keep,
   input  logic                 pci_keep,
   output logic [NUM_GATES-1:0] gates
);
   logic [NUM_GATES-1:0] drv_q;
   logic [NUM_GATES-1:0] tgt;
   logic [NUM_GATES-1:0] falling;

   always_comb begin
      tgt     = gate_target(st, usb_keep, pci_keep, run_ok);
      falling = drv_q & ~tgt;
   end

   always_ff @(posedge clk) begin
      if (rst)           drv_q <= '0;
      else if (|falling) drv_q <= drv_q & tgt;
      else               drv_q <= tgt;
   end

   assign gates = drv_q;

endmodule

// File: rtl/slp_gate_ctrl.sv
module slp_gate_ctrl
   import slp_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 slp3_n,
   input  logic                 slp5_n,
   input  logic                 pwr_ok,
   input  logic                 usb_sb_en,
   input  logic                 pci_sb_en,
   input  logic                 agp_type_hi,
   input  logic                 en,
   input  logic                 supply_good,
   input  logic                 oc_fault,
   output logic [NUM_GATES-1:0] gate_o,
   output logic [1:0]           state_o,
   output logic                 agp_sel_o
);
   logic [2:0] filt;
   logic       fault_q;
   logic       run_ok;
   pstate_e    st;

   slp_in_filter #(
      .WIDTH        (3),
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
   ) u_filt (
      .clk (clk),
      .rst (rst),
      .din ({slp3_n, slp5_n, pwr_ok}),
      .dout(filt)
   );

   always_ff @(posedge clk) begin
      if (rst || !en || !supply_good) fault_q <= 1'b0;
      else if (oc_fault)              fault_q <= 1'b1;
   end

   assign run_ok = en & supply_good & ~fault_q;

   slp_state_fsm u_fsm (
      .clk   (clk),
      .rst   (rst),
      .run_ok(run_ok),
      .s3n   (filt[2]),
      .s5n   (filt[1]),
      .pok   (filt[0]),
      .st    (st)
   );

   slp_gate_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .st      (st),
      .run_ok  (run_ok),
      .usb_keep(usb_sb_en),
      .pci_keep(pci_sb_en),
      .gates   (gate_o)
   );

   always_ff @(posedge clk) begin
      if (rst) agp_sel_o <= 1'b0;
      else     agp_sel_o <= agp_type_hi;
   end

   assign state_o = st;

endmodule

// File: rtl/slp_gate_ctrl_chk.sv
module slp_gate_ctrl_chk (
   input logic       clk,
   input logic       rst,
   input logic [7:0] gate_o,
   input logic [1:0] state_o,
   input logic       agp_sel_o,
   input logic       agp_type_hi,
   input logic       run_ok
);
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (state_o == 2'b10 && gate_o == 8'h00));

   a_r2_valid_code: assert property (@(posedge clk) disable iff (rst)
      state_o != 2'b11);

   a_r4_no_s3_to_s5: assert property (@(posedge clk) disable iff (rst)
      (state_o == 2'b01 && run_ok) |=> state_o != 2'b10);

   a_r4_no_s5_to_s3: assert property (@(posedge clk) disable iff (rst)
      state_o == 2'b10 |=> state_o != 2'b01);

   a_r9_agp_follows: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> agp_sel_o == $past(agp_type_hi));

   a_r11_shutdown: assert property (@(posedge clk) disable iff (rst)
      !run_ok |=> (state_o == 2'b10 && gate_o == 8'h00));

   a_r12_pairs_apart: assert property (@(posedge clk) disable iff (rst)
      !(gate_o[0] & gate_o[1]) && !(gate_o[2] & gate_o[3]) && !(gate_o[4] & gate_o[5]));

   a_r12_no_rise_with_fall: assert property (@(posedge clk) disable iff (rst)
      (|(gate_o & ~$past(gate_o))) |-> ((~gate_o & $past(gate_o)) == 8'h00));

endmodule

bind slp_gate_ctrl slp_gate_ctrl_chk chk_i (
   .clk        (clk),
   .rst        (rst),
   .gate_o     (gate_o),
   .state_o    (state_o),
   .agp_sel_o  (agp_sel_o),
   .agp_type_hi(agp_type_hi),
   .run_ok     (run_ok)
);

// File: tb/slp_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module slp_gate_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic slp3_n = 1'b0, slp5_n = 1'b0, pwr_ok = 1'b0;
   logic usb_sb_en = 1'b0, pci_sb_en = 1'b0, agp_type_hi = 1'b0;
   logic en = 1'b1, supply_good = 1'b1, oc_fault = 1'b0;
   logic [7:0] gate_o;
   logic [1:0] state_o;
   logic       agp_sel_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   slp_gate_ctrl dut_i (
      .clk(clk), .rst(rst), .slp3_n(slp3_n), .slp5_n(slp5_n), .pwr_ok(pwr_ok),
      .usb_sb_en(usb_sb_en), .pci_sb_en(pci_sb_en), .agp_type_hi(agp_type_hi),
      .en(en), .supply_good(supply_good), .oc_fault(oc_fault),
      .gate_o(gate_o), .state_o(state_o), .agp_sel_o(agp_sel_o)
   );

   localparam logic [1:0] ST0 = 2'b00, ST3 = 2'b01, ST5 = 2'b10;

   // {slp3_n, slp5_n, pwr_ok, usb, pci, exp_state, exp_gates}
   localparam int NV = 16;
   localparam logic [14:0] VEC [NV] = '{
      {5'b000_00, ST5, 8'hC0},   // R7 S5 nothing kept
      {5'b000_10, ST5, 8'hC1},   // R7 usb kept
      {5'b000_01, ST5, 8'hC8},   // R7 pci kept
      {5'b000_11, ST5, 8'hC9},   // R7 both kept, R8
      {5'b100_11, ST5, 8'hC9},   // R2 invalid pattern
      {5'b110_11, ST5, 8'hC9},   // R2 no power-good
      {5'b111_11, ST0, 8'hD6},   // R2 enter S0, R6
      {5'b110_11, ST0, 8'hD6},   // R5 power-good lost
      {5'b111_00, ST0, 8'hD6},   // R7 straps ignored in S0
      {5'b011_00, ST3, 8'hE9},   // R3 S0 to S3, R6
      {5'b011_11, ST3, 8'hE9},   // R7 straps ignored in S3
      {5'b000_11, ST3, 8'hE9},   // R4 S3 to S5 ignored
      {5'b111_00, ST0, 8'hD6},   // R4 S3 to S0
      {5'b000_00, ST5, 8'hC0},   // R3 S0 to S5
      {5'b010_00, ST5, 8'hC0},   // R4 S5 does not enter S3
      {5'b111_00, ST0, 8'hD6}    // R2 back to S0
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int viol;
      int pair_bad;
      bit seen_gap;
      logic [7:0] prev;
      wait_neg(3);
      chk("R1 reset state", {30'd0, state_o}, {30'd0, ST5});
      chk("R1 reset gates", {24'd0, gate_o}, 32'h00);
      rst = 1'b0;
      wait_neg(12);

      for (int i = 0; i < NV; i++) begin
         {slp3_n, slp5_n, pwr_ok, usb_sb_en, pci_sb_en} = VEC[i][14:10];
         wait_neg(12);
         chk($sformatf("R3 state vec %0d", i), {30'd0, state_o}, {30'd0, VEC[i][9:8]});
         chk($sformatf("R6 gates vec %0d", i), {24'd0, gate_o}, {24'd0, VEC[i][7:0]});
      end

      // R12: S0 to S3 ordering, sampled every cycle
      viol = 0; pair_bad = 0; seen_gap = 1'b0; prev = gate_o;
      slp3_n = 1'b0;
      for (int c = 0; c < 14; c++) begin
         @(negedge clk);
         if (((gate_o & ~prev) != 0) && ((~gate_o & prev) != 0)) viol++;
         if ((gate_o[0] & gate_o[1]) | (gate_o[2] & gate_o[3]) | (gate_o[4] & gate_o[5])) pair_bad++;
         if (gate_o == 8'hC0) seen_gap = 1'b1;
         prev = gate_o;
      end
      chk("R12 rise with fall", viol, 0);
      chk("R12 pair overlap", pair_bad, 0);
      chk("R12 off gap seen", {31'd0, seen_gap}, 1);
      chk("R6 S3 gates", {24'd0, gate_o}, 32'hE9);

      // R10: one-cycle pulse toward S0 ignored
      slp3_n = 1'b1;
      @(negedge clk);
      slp3_n = 1'b0;
      wait_neg(12);
      chk("R10 glitch ignored", {30'd0, state_o}, {30'd0, ST3});

      // R11: enable low forces S5, gates off
      en = 1'b0;
      wait_neg(3);
      chk("R11 en low state", {30'd0, state_o}, {30'd0, ST5});
      chk("R11 en low gates", {24'd0, gate_o}, 32'h00);
      chk("R8 rails off without en", {31'd0, gate_o[7] | gate_o[6]}, 0);
      en = 1'b1;
      wait_neg(12);
      chk("R4 S5 stays with S3 pattern", {24'd0, gate_o}, 32'hC0);
      slp3_n = 1'b1;
      wait_neg(12);
      chk("R2 S0 after enable", {30'd0, state_o}, {30'd0, ST0});

      // R11: fault pulse latches
      oc_fault = 1'b1;
      @(negedge clk);
      oc_fault = 1'b0;
      wait_neg(8);
      chk("R11 fault latched state", {30'd0, state_o}, {30'd0, ST5});
      chk("R11 fault latched gates", {24'd0, gate_o}, 32'h00);
      en = 1'b0;
      wait_neg(2);
      en = 1'b1;
      wait_neg(12);
      chk("R11 recovered after en cycle", {24'd0, gate_o}, 32'hD6);

      // R11: supply-good loss
      supply_good = 1'b0;
      wait_neg(3);
      chk("R11 supply lost gates", {24'd0, gate_o}, 32'h00);
      supply_good = 1'b1;
      wait_neg(12);
      chk("R11 supply back state", {30'd0, state_o}, {30'd0, ST0});

      // R9: graphics select
      agp_type_hi = 1'b1;
      wait_neg(2);
      chk("R9 select high", {31'd0, agp_sel_o}, 1);
      agp_type_hi = 1'b0;
      wait_neg(2);
      chk("R9 select low", {31'd0, agp_sel_o}, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule